// File: doc/BRIEF.md
# NAND Flash Controller Register Bank

This block is the register file of a NAND flash controller. A processor reaches it over a small valid/ready register bus. It holds two registers guarded by a key: the interface configuration and the timing word. It also holds an interrupt mask, a sticky interrupt status that clears when it is read, and a live status view of the flash and ECC engine. The NAND pins, the ECC engine and the page buffer are outside this block. They report to it through one-cycle event pulses and live level inputs.

A guarded register can be changed only once per unlock. Software first writes the 16-bit key to the lock register. The next write to any other address consumes that unlock. If that write targets the configuration or timing register, the new value is stored. The lock then closes again by itself. The interrupt line is a level signal, high while any status bit is set and its mask bit is also set. A command write of 0xFF performs a soft reset of the register state.

Top module: `nfc_regbank`

Register offsets are word addresses: 0 command, 1 lock, 2 configuration, 3 timing, 4 interrupt mask, 5 interrupt status, 6 live status. Address 7 is unmapped and reads as zero.

## Requirements
- R1: After reset, the block is in this state: the lock is closed (the lock register reads 0), the configuration reads 0, the timing word equals its reset parameter, the mask and status read 0, and `irq` and `soft_reset` are low.
- R2: A write of 0xA25E to bits 15:0 of the lock register opens the lock. While the lock is open, bit 0 of the lock register reads 1. Reads never change the lock.
- R3: While the lock is closed, a write to the configuration or timing register is ignored and leaves the lock closed.
- R4: While the lock is open, one write to the configuration or timing register takes effect and closes the lock, so a second write is ignored.
- R5: The configuration register is 4 bits wide and is driven on `cfg_o`. Bit 3 enables write protect, bit 2 selects a large-block device, bit 1 selects a 5-byte address and bit 0 selects a 16-bit bus.
- R6: Any of the following closes the lock: a write to any address other than the lock register (including the unmapped one), or a lock write without the key.
- R7: A one-cycle pulse on `evt_in` sets the matching bit of the interrupt status register, and the bit stays set until it is cleared. The bit layout, shared by the mask, is: bit 5 NAND ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault.
- R8: A read of the interrupt status register returns its contents and clears every bit.
- R9: An event that arrives in the same cycle as a status read is not returned by that read, but stays set afterwards.
- R10: `irq` is high exactly while some status bit and the same mask bit are both set.
- R11: A read of the live status register returns the live inputs in this layout: bit 6 decoder failure, bits 5:4 corrected count minus one, bit 3 errors detected, bit 2 ECC ready, bit 1 controller ready, bit 0 NAND ready.
- R12: A write of 0xFF to bits 7:0 of the command register pulses `soft_reset` for one cycle. The same write clears the status, closes the lock, and returns the configuration, timing and mask to their reset values. Other command values only close the lock.
- R13: A read returns its data with `rsp_valid` high in the following cycle. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| evt_in | input | 6 | Event pulses in the status layout |
| lv_dec_fail | input | 1 | Live decoder failure |
| lv_err_cnt | input | 2 | Live corrected count minus one |
| lv_err_det | input | 1 | Live errors detected |
| lv_ecc_rdy | input | 1 | Live ECC ready |
| lv_ctrl_rdy | input | 1 | Live controller ready |
| lv_nand_rdy | input | 1 | Live NAND ready |
| cfg_o | output | 4 | Configuration register |
| timing_o | output | TIM_W | Timing register |
| irq | output | 1 | Level interrupt |
| soft_reset | output | 1 | One-cycle soft-reset pulse |

## Verification
Two functions can fall in the same cycle: an event pulse setting a status bit, and a status read clearing it. The bench provokes this by asserting one event first. It then raises a second event on the same edge that samples the read. It judges the result by two readings: the first read must return only the earlier event, and the next read must return the event that coincided with the first read. A second collision is between the one-shot unlock and the write that consumes it. The bench probes this by writing the guarded register twice after one unlock.

// File: rtl/nfc_regbank.sv
module nfc_regbank #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int TIM_W   = 27,
  parameter logic [15:0] KEY = 16'hA25E,
  parameter logic [7:0]  CMD_SRST = 8'hFF,
  parameter logic [TIM_W-1:0] TIM_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [5:0]        evt_in,
  input  logic              lv_dec_fail,
  input  logic [1:0]        lv_err_cnt,
  input  logic              lv_err_det,
  input  logic              lv_ecc_rdy,
  input  logic              lv_ctrl_rdy,
  input  logic              lv_nand_rdy,
  output logic [3:0]        cfg_o,
  output logic [TIM_W-1:0]  timing_o,
  output logic              irq,
  output logic              soft_reset
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(6);

  logic       unlocked;
  logic [5:0] mask, stat;
  logic [DATA_W-1:0] rd_mux;

  wire wr      = bus_valid &  bus_write;
  wire rd      = bus_valid & ~bus_write;
  wire key_ok  = wr && bus_addr == A_LOCK && bus_wdata[15:0] == KEY;
  wire cmd_rst = wr && bus_addr == A_CMD && bus_wdata[7:0] == CMD_SRST;
  wire stat_rd = rd && bus_addr == A_STAT;

  assign bus_ready = 1'b1;
  assign irq = |(stat & mask);

  always_comb begin
    case (bus_addr)
      A_LOCK:  rd_mux = DATA_W'(unlocked);
      A_CFG:   rd_mux = DATA_W'(cfg_o);
      A_TIM:   rd_mux = DATA_W'(timing_o);
      A_MASK:  rd_mux = DATA_W'(mask);
      A_STAT:  rd_mux = DATA_W'(stat);
      A_LIVE:  rd_mux = DATA_W'({lv_dec_fail, lv_err_cnt, lv_err_det,
                                 lv_ecc_rdy, lv_ctrl_rdy, lv_nand_rdy});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked   <= 1'b0;
      cfg_o      <= '0;
      timing_o   <= TIM_RST;
      mask       <= '0;
      stat       <= '0;
      soft_reset <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      soft_reset <= cmd_rst;
      rsp_valid  <= rd;
      if (rd) rsp_rdata <= rd_mux;
      stat <= ((cmd_rst || stat_rd) ? 6'b0 : stat) | evt_in;
      if (cmd_rst) begin
        unlocked <= 1'b0;
        cfg_o    <= '0;
        timing_o <= TIM_RST;
        mask     <= '0;
      end else if (wr) begin
        unlocked <= key_ok;
        if (unlocked && bus_addr == A_CFG) cfg_o    <= bus_wdata[3:0];
        if (unlocked && bus_addr == A_TIM) timing_o <= bus_wdata[TIM_W-1:0];
        if (bus_addr == A_MASK)            mask     <= bus_wdata[5:0];
      end
    end
  end
endmodule

module nfc_regbank_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rsp_valid,
  input logic [5:0]        evt_in,
  input logic [5:0]        stat,
  input logic [5:0]        mask,
  input logic              unlocked,
  input logic [3:0]        cfg_o,
  input logic              irq,
  input logic              soft_reset
);
  wire wr = bus_valid && bus_write;
  wire rd = bus_valid && !bus_write;
  wire srst_req = wr && bus_addr == ADDR_W'(0) && bus_wdata[7:0] == 8'hFF;

  p_locked_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == ADDR_W'(2) && !unlocked |=> $stable(cfg_o) && !unlocked);

  p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == ADDR_W'(2) && unlocked |=> !unlocked);

  p_other_write_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr != ADDR_W'(1) |=> !unlocked);

  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_in |=> (stat & $past(evt_in)) == $past(evt_in));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && bus_addr == ADDR_W'(5)) && !srst_req |=> (stat & $past(stat)) == $past(stat));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == ADDR_W'(5) |=> stat == $past(evt_in));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 6'b0 |-> !irq);

  p_srst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> soft_reset && !unlocked && cfg_o == 4'b0);

  p_rsp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid == $past(rd));
endmodule

bind nfc_regbank nfc_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
  .evt_in(evt_in), .stat(stat), .mask(mask), .unlocked(unlocked),
  .cfg_o(cfg_o), .irq(irq), .soft_reset(soft_reset)
);

// File: tb/nfc_regbank_tb.sv
module nfc_regbank_tb;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int TIM_W  = 27;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [5:0] evt_in = '0;
  logic lv_dec_fail = 0, lv_err_det = 0, lv_ecc_rdy = 0, lv_ctrl_rdy = 0, lv_nand_rdy = 0;
  logic [1:0] lv_err_cnt = '0;
  logic bus_ready, rsp_valid, irq, soft_reset;
  logic [DATA_W-1:0] rsp_rdata;
  logic [3:0] cfg_o;
  logic [TIM_W-1:0] timing_o;
  int tests = 0, fails = 0;
  logic [DATA_W-1:0] rv;

  always #5 clk = ~clk;

  nfc_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_in(evt_in),
    .lv_dec_fail(lv_dec_fail), .lv_err_cnt(lv_err_cnt), .lv_err_det(lv_err_det),
    .lv_ecc_rdy(lv_ecc_rdy), .lv_ctrl_rdy(lv_ctrl_rdy), .lv_nand_rdy(lv_nand_rdy),
    .cfg_o(cfg_o), .timing_o(timing_o), .irq(irq), .soft_reset(soft_reset)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
    bus_valid = 0;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk); evt_in = e;
    @(negedge clk); evt_in = '0;
  endtask

  // {req[3:0], op[1:0] (1 write, 2 read), addr[2:0], data[31:0], exp[31:0]}
  localparam int NV = 27;
  localparam logic [72:0] VEC [NV] = '{
    {4'd1,  2'd2, 3'd1, 32'h0,        32'h0},         // R1 locked
    {4'd3,  2'd1, 3'd2, 32'hF,        32'h0},         // R3
    {4'd3,  2'd2, 3'd2, 32'h0,        32'h0},         // R3 ignored
    {4'd3,  2'd2, 3'd1, 32'h0,        32'h0},         // R3 still locked
    {4'd2,  2'd1, 3'd1, 32'hA25E,     32'h0},         // R2
    {4'd2,  2'd2, 3'd1, 32'h0,        32'h1},         // R2 open
    {4'd4,  2'd1, 3'd2, 32'h6,        32'h0},         // R4
    {4'd4,  2'd2, 3'd2, 32'h0,        32'h6},         // R4 applied
    {4'd4,  2'd2, 3'd1, 32'h0,        32'h0},         // R4 relocked
    {4'd4,  2'd1, 3'd2, 32'h9,        32'h0},         // R4
    {4'd4,  2'd2, 3'd2, 32'h0,        32'h6},         // R4 one shot
    {4'd4,  2'd1, 3'd1, 32'hA25E,     32'h0},
    {4'd4,  2'd1, 3'd3, 32'hF123_4567, 32'h0},
    {4'd4,  2'd2, 3'd3, 32'h0,        32'h0123_4567}, // R4 timing
    {4'd6,  2'd1, 3'd1, 32'hA25E,     32'h0},
    {4'd6,  2'd1, 3'd4, 32'h3F,       32'h0},
    {4'd6,  2'd2, 3'd1, 32'h0,        32'h0},         // R6 mask write relocks
    {4'd6,  2'd1, 3'd2, 32'h5,        32'h0},
    {4'd6,  2'd2, 3'd2, 32'h0,        32'h6},         // R6
    {4'd6,  2'd1, 3'd1, 32'hA25E,     32'h0},
    {4'd6,  2'd1, 3'd1, 32'h1234,     32'h0},
    {4'd6,  2'd2, 3'd1, 32'h0,        32'h0},         // R6 bad key
    {4'd6,  2'd1, 3'd1, 32'hA25E,     32'h0},
    {4'd6,  2'd1, 3'd7, 32'hFFFF,     32'h0},
    {4'd6,  2'd2, 3'd1, 32'h0,        32'h0},         // R6 unmapped
    {4'd13, 2'd2, 3'd7, 32'h0,        32'h0},         // R13 unmapped reads 0
    {4'd13, 2'd2, 3'd4, 32'h0,        32'h3F}         // R13
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cfg", 32'(cfg_o), 32'h0);
    check("R1 timing", 32'(timing_o), 32'h0);
    check("R1 irq/srst", {30'b0, irq, soft_reset}, 32'h0);
    rd(3'd5, rv); check("R1 status", rv, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68:67] == 2'd1) wr(VEC[i][66:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][66:64], rv);
        tests++;
        if (rv !== VEC[i][31:0]) begin
          fails++;
          $display("FAIL R%0d vector %0d: got %h expected %h", VEC[i][72:69], i, rv, VEC[i][31:0]);
        end
      end
    end
    check("R5 cfg_o large-block+long-addr", 32'(cfg_o), 32'h6);

    pulse(6'h20);
    check("R10 irq raised", 32'(irq), 32'h1);
    check("R7 status holds", 32'(irq), 32'h1);
    rd(3'd5, rv); check("R8 status read", rv, 32'h20);
    rd(3'd5, rv); check("R8 cleared", rv, 32'h0);
    check("R10 irq cleared", 32'(irq), 32'h0);

    wr(3'd4, 32'h01);
    pulse(6'h02);
    check("R10 masked event", 32'(irq), 32'h0);
    rd(3'd5, rv); check("R7 masked bit set", rv, 32'h02);
    pulse(6'h01);
    check("R10 unmasked event", 32'(irq), 32'h1);
    rd(3'd5, rv); check("R8 wp fault", rv, 32'h01);

    pulse(6'h08);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 3'd5; evt_in = 6'h04;
    @(negedge clk);
    bus_valid = 0; evt_in = '0;
    check("R9 read excludes coincident event", rsp_rdata, 32'h08);
    rd(3'd5, rv); check("R9 coincident event kept", rv, 32'h04);

    lv_dec_fail = 1; lv_err_cnt = 2'd2; lv_err_det = 1; lv_ecc_rdy = 0;
    lv_ctrl_rdy = 1; lv_nand_rdy = 0;
    rd(3'd6, rv); check("R11 live status", rv, 32'h6A);

    wr(3'd1, 32'hA25E); wr(3'd2, 32'hA);
    check("R5 cfg_o wp+long", 32'(cfg_o), 32'hA);
    pulse(6'h10);
    wr(3'd1, 32'hA25E);
    wr(3'd0, 32'hFF);
    check("R12 soft_reset pulse", 32'(soft_reset), 32'h1);
    check("R12 cfg restored", 32'(cfg_o), 32'h0);
    @(negedge clk);
    check("R12 pulse one cycle", 32'(soft_reset), 32'h0);
    rd(3'd1, rv); check("R12 relocked", rv, 32'h0);
    rd(3'd5, rv); check("R12 status cleared", rv, 32'h0);
    rd(3'd4, rv); check("R12 mask cleared", rv, 32'h0);
    wr(3'd1, 32'hA25E); wr(3'd2, 32'h3);
    wr(3'd1, 32'hA25E); wr(3'd0, 32'h12);
    check("R12 other command no reset", 32'(soft_reset), 32'h0);
    rd(3'd1, rv); check("R12 other command relocks", rv, 32'h0);
    check("R12 cfg kept", 32'(cfg_o), 32'h3);

    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 3'd4; bus_wdata = 32'h0;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check("R13 no response on write", 32'(rsp_valid), 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule